// File: doc/BRIEF.md
# Peripheral ROM Overlay Controller

This block watches the processor bus and decides, for four sub-ranges of the 0xC100–0xCFFF peripheral window, whether the on-board ROM or a plug-in card answers an access. Two soft-switch flags set the decision. The internal-ROM flag hands the whole window to the on-board ROM. The slot-3 flag gives the 0xC3xx page back to a card.

A third bit of state, the expansion-ROM latch, arms itself when software touches the 0xC3xx page while that page belongs to the on-board ROM. While armed, it hands the upper 2 KiB (0xC800–0xCFFF) to the on-board ROM. Any access to 0xCFFF disarms it.

The block registers its four select bits. Address decode and card steering read them directly. A one-cycle change strobe tells downstream paging logic that at least one select bit has moved.

Top module: `prom_overlay_ctrl`

## Requirements
- R1: After a synchronous reset, `rom_sel` is 4'b0010 (only 0xC300–0xC3FF on-board) and `sel_change` is 0. The flags and the latch are clear.
- R2: A valid write to 0xC006 or 0xC007 loads the internal-ROM flag from address bit 0. A read of those addresses leaves the flag unchanged.
- R3: A valid write to 0xC00A or 0xC00B loads the slot-3 flag from address bit 0. A read of those addresses leaves the flag unchanged.
- R4: A valid access (read or write) with address bits 15:8 equal to 0xC3 sets the expansion latch when the slot-3 flag is clear. When the slot-3 flag is set, such an access leaves the latch unchanged.
- R5: A valid access to 0xCFFF clears the expansion latch.
- R6: `rom_sel[0]` (0xC100–0xC2FF) and `rom_sel[2]` (0xC400–0xC7FF) each equal the internal-ROM flag.
- R7: `rom_sel[1]` (0xC300–0xC3FF) is 1 when the internal-ROM flag is set, or when both the internal-ROM flag and the slot-3 flag are clear.
- R8: `rom_sel[3]` (0xC800–0xCFFF) is 1 when the internal-ROM flag or the expansion latch is set.
- R9: `sel_change` is 1 for exactly the cycle in which `rom_sel` first shows a new value, and 0 whenever `rom_sel` keeps its value.
- R10: When `bus_valid` is 0, no state changes, whatever the address and direction. `rom_sel` holds and `sel_change` stays 0.
- R11: Each bus access becomes visible on `rom_sel` and `sel_change` after one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Qualifies the bus cycle in this clock |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| rom_sel | output | 4 | Overlay selects: bit0 C1–C2, bit1 C3, bit2 C4–C7, bit3 C8–CF; 1 = on-board ROM |
| sel_change | output | 1 | One-cycle pulse when any select bit changes |

## Verification
The latch update and the change strobe can act on the same access while pulling in different directions. The internal-ROM flag already forces the 0xC800 range on-board. In that state, a 0xC3xx access that arms the latch, or a 0xCFFF access that disarms it, changes state but must leave `sel_change` low. The bench sets up this condition and then drops the internal-ROM flag. The resulting `rom_sel[3]` shows whether the hidden latch update really happened.

// File: rtl/prom_pkg.sv
package prom_pkg;

    localparam int ADDR_W   = 16;
    localparam int REGION_N = 4;

    // Soft-switch pairs, compared on address bits [15:1]
    localparam logic [ADDR_W-1:0] SW_INTROM_BASE = 16'hC006;
    localparam logic [ADDR_W-1:0] SW_SLOT3_BASE  = 16'hC00A;
    // Expansion latch trigger page and release address
    localparam logic [7:0]        ARM_PAGE       = 8'hC3;
    localparam logic [ADDR_W-1:0] DISARM_ADDR    = 16'hCFFF;

    typedef struct packed {
        logic hi_c8;   // 0xC800-0xCFFF
        logic lo_c4;   // 0xC400-0xC7FF
        logic pg_c3;   // 0xC300-0xC3FF
        logic lo_c1;   // 0xC100-0xC2FF
    } overlay_t;

    typedef struct packed {
        logic introm;
        logic slot3;
    } switch_t;

    typedef struct packed {
        logic                valid;
        logic                write;
        logic [ADDR_W-1:0]   addr;
    } bus_t;

    function automatic logic is_pair(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
        return a[ADDR_W-1:1] == base[ADDR_W-1:1];
    endfunction

    function automatic overlay_t map_overlay(input switch_t sw, input logic latch);
        overlay_t o;
        o.lo_c1 = sw.introm;
        o.lo_c4 = sw.introm;
        o.pg_c3 = sw.introm | ~sw.slot3;
        o.hi_c8 = sw.introm | latch;
        return o;
    endfunction

endpackage

// File: rtl/prom_switch_decode.sv
module prom_switch_decode
    import prom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_t    bus,
    output switch_t sw_d,
    output switch_t sw_q
);

    logic wr_ok;
    assign wr_ok = bus.valid & bus.write;

    always_comb begin
        sw_d = sw_q;
        if (wr_ok && is_pair(bus.addr, SW_INTROM_BASE))
            sw_d.introm = bus.addr[0];
        if (wr_ok && is_pair(bus.addr, SW_SLOT3_BASE))
            sw_d.slot3 = bus.addr[0];
    end

    always_ff @(posedge clk) begin
        if (rst) sw_q <= '0;
        else     sw_q <= sw_d;
    end

endmodule

// File: rtl/prom_exp_latch.sv
module prom_exp_latch
    import prom_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  bus_t bus,
    input  logic slot3,
    output logic latch_d,
    output logic latch_q
);

    logic arm_hit, disarm_hit;
    assign arm_hit    = bus.valid && (bus.addr[ADDR_W-1:ADDR_W-8] == ARM_PAGE) && !slot3;
    assign disarm_hit = bus.valid && (bus.addr == DISARM_ADDR);

    // Release wins over arming
    always_comb begin
        latch_d = latch_q;
        if (arm_hit)    latch_d = 1'b1;
        if (disarm_hit) latch_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) latch_q <= 1'b0;
        else     latch_q <= latch_d;
    end

endmodule

// File: rtl/prom_overlay_out.sv
module prom_overlay_out
    import prom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  overlay_t ov_next,
    output overlay_t ov_q,
    output logic     change_q
);

    localparam overlay_t OV_RESET = map_overlay('0, 1'b0);

    logic [REGION_N-1:0] diff;

    generate
        for (genvar i = 0; i < REGION_N; i++) begin : g_diff
            assign diff[i] = ov_next[i] ^ ov_q[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q     <= OV_RESET;
            change_q <= 1'b0;
        end else begin
            ov_q     <= ov_next;
            change_q <= |diff;
        end
    end

endmodule

// File: rtl/prom_overlay_ctrl.sv
module prom_overlay_ctrl
    import prom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [REGION_N-1:0] rom_sel,
    output logic              sel_change
);

    bus_t     bus;
    switch_t  sw_d, sw_q;
    logic     latch_d, latch_q;
    overlay_t ov_next, ov_q;
    logic     slot3_q;

    assign bus.valid = bus_valid;
    assign bus.write = bus_write;
    assign bus.addr  = bus_addr;

    prom_switch_decode u_sw (
        .clk  (clk),
        .rst  (rst),
        .bus  (bus),
        .sw_d (sw_d),
        .sw_q (sw_q)
    );

    // Latch arming sees the slot-3 flag as held before this access
    prom_exp_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .slot3   (sw_q.slot3),
        .latch_d (latch_d),
        .latch_q (latch_q)
    );

    assign ov_next = map_overlay(sw_d, latch_d);

    prom_overlay_out u_out (
        .clk      (clk),
        .rst      (rst),
        .ov_next  (ov_next),
        .ov_q     (ov_q),
        .change_q (sel_change)
    );

    assign rom_sel = ov_q;
    assign slot3_q = sw_q.slot3;

endmodule

// File: rtl/prom_overlay_chk.sv
module prom_overlay_chk
    import prom_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [REGION_N-1:0] rom_sel,
    input logic                sel_change,
    input logic                slot3_q
);

    p_change_iff_moved_r9: assert property (@(posedge clk) disable iff (rst)
        sel_change == (rom_sel != $past(rom_sel)));

    p_low_pair_r6: assert property (@(posedge clk) disable iff (rst)
        rom_sel[0] == rom_sel[2]);

    p_c3_follows_int_r7: assert property (@(posedge clk) disable iff (rst)
        rom_sel[0] |-> rom_sel[1]);

    p_c8_follows_int_r8: assert property (@(posedge clk) disable iff (rst)
        rom_sel[0] |-> rom_sel[3]);

    p_disarm_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr == DISARM_ADDR && !rom_sel[0]) |=> !rom_sel[3]);

    p_arm_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr[15:8] == ARM_PAGE && !slot3_q) |=> rom_sel[3]);

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> ($stable(rom_sel) && !sel_change));

    p_read_keeps_int_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> (rom_sel[0] == $past(rom_sel[0])));

endmodule

bind prom_overlay_ctrl prom_overlay_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .rom_sel    (rom_sel),
    .sel_change (sel_change),
    .slot3_q    (slot3_q)
);

// File: tb/prom_overlay_ctrl_bench.sv
module prom_overlay_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr  = 16'h0000;
    logic [3:0]  rom_sel;
    logic        sel_change;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    typedef struct {
        logic [3:0] sel;
        logic       stb;
        string      tag;
    } exp_t;

    exp_t scb[$];

    // reference model state
    bit m_int = 0, m_s3 = 0, m_lat = 0;
    logic [3:0] m_sel = 4'b0010;

    always #2 clk = ~clk;   // 250 MHz

    prom_overlay_ctrl u_prom_overlay_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .rom_sel    (rom_sel),
        .sel_change (sel_change)
    );

    function automatic logic [3:0] model_sel();
        logic [3:0] s;
        s[0] = m_int;
        s[2] = m_int;
        s[1] = m_int | (!m_int & !m_s3);
        s[3] = m_int | m_lat;
        return s;
    endfunction

    task automatic cycle(input bit v, input bit wr, input logic [15:0] a, input string tag);
        exp_t e;
        logic [3:0] ns;
        bit old_s3;
        @(negedge clk);
        bus_valid = v;
        bus_write = wr;
        bus_addr  = a;
        old_s3 = m_s3;
        if (v) begin
            if (wr && a[15:1] == 15'h6003) m_int = a[0];
            if (wr && a[15:1] == 15'h6005) m_s3  = a[0];
            if (a[15:8] == 8'hC3 && !old_s3) m_lat = 1;
            if (a == 16'hCFFF) m_lat = 0;
        end
        ns = model_sel();
        e.sel = ns;
        e.stb = (ns != m_sel);
        e.tag = tag;
        m_sel = ns;
        @(posedge clk);
        scb.push_back(e);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // monitor: sample 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (scb.size() > 0) begin
                exp_t e;
                e = scb.pop_front();
                checks++;
                if (rom_sel !== e.sel || sel_change !== e.stb) begin
                    failures++;
                    $display("FAIL %s: rom_sel=%b sel_change=%b expected rom_sel=%b sel_change=%b",
                             e.tag, rom_sel, sel_change, e.sel, e.stb);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        checks++;
        if (rom_sel !== 4'b0010 || sel_change !== 1'b0) begin
            failures++;
            $display("FAIL R1: rom_sel=%b sel_change=%b expected rom_sel=0010 sel_change=0",
                     rom_sel, sel_change);
        end
        cycle(1, 0, 16'hC007, "R2 read of switch ignored");
        cycle(1, 1, 16'hC007, "R6 R11 internal flag on");
        cycle(0, 1, 16'hC006, "R10 invalid write ignored");
        cycle(1, 1, 16'hC006, "R9 internal flag off");
        cycle(1, 0, 16'hC00B, "R3 read of slot3 ignored");
        cycle(1, 1, 16'hC00B, "R7 slot3 set gives C3 to card");
        cycle(1, 0, 16'hC355, "R4 C3 access with slot3 set");
        cycle(1, 1, 16'hC008, "R10 unrelated switch no effect");
        cycle(1, 1, 16'hC00A, "R7 slot3 clear");
        cycle(0, 0, 16'hC300, "R10 invalid C3 access ignored");
        cycle(1, 0, 16'hC3A0, "R4 R8 latch armed");
        cycle(1, 0, 16'hCFFF, "R5 latch released");
        cycle(1, 1, 16'hC3FF, "R4 write arms latch");
        cycle(1, 1, 16'hC00B, "R7 slot3 set keeps C8");
        cycle(1, 0, 16'hC300, "R4 slot3 blocks arm");
        cycle(1, 1, 16'hCFFF, "R5 write releases");
        cycle(1, 1, 16'hC00A, "R7 slot3 clear again");
        // same-cycle interplay with internal flag already on
        cycle(1, 1, 16'hC007, "R6 internal on");
        cycle(1, 0, 16'hC310, "R9 hidden arm no strobe");
        cycle(1, 1, 16'hC006, "R8 latch survives hidden arm");
        cycle(1, 1, 16'hC007, "R6 internal on again");
        cycle(1, 0, 16'hCFFF, "R9 hidden release no strobe");
        cycle(1, 1, 16'hC006, "R5 latch cleared while hidden");
        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule